// File: doc/BRIEF.md
# Sync-Presence Power State Controller

This block watches the horizontal and vertical sync inputs of a display and decides which power-management state the display should be in. Each sync line has its own activity detector. The detector counts microsecond ticks since the last edge on that line and declares the sync missing once a timeout passes. The two presence flags select one of four states. A move into a power-saving state, or from one saving state to another, takes effect only after the new combination has held for a set number of vertical-timeout intervals. A return to full operation takes effect at once.

From the adopted state the block drives a two-colour indicator, an enable for the deflection supply rail and a single blank request. The blank request also covers a hold window after an external mode-change flag and the vertical retrace strobe.

Top module: `sync_power_ctrl`

## Requirements
- R1: The state output `pm_state_o` uses the encoding 2'b00 Normal, 2'b01 Standby (hsync missing, vsync present), 2'b10 Suspend (hsync present, vsync missing) and 2'b11 Off (both missing).
- R2: `led_green_o` is lit only in Normal and `led_amber_o` only outside Normal. Exactly one of the two is lit at any time.
- R3: `rail_en_o` is high in Normal and low in every other state, following the state by one clock.
- R4: `hsync_ok_o` rises within four clocks of an hsync edge. It falls once HS_TIMEOUT_US microsecond ticks pass with no edge.
- R5: `vsync_ok_o` rises within four clocks of a vsync edge. It falls once VS_TIMEOUT_US ticks pass with no edge.
- R6: A presence combination other than both-present is adopted as the new state only after it has persisted across PERSIST_INTERVALS interval pulses, where one interval pulse comes every VS_TIMEOUT_US ticks. Until then the previous state is kept.
- R7: When both syncs are present, the state becomes Normal on the next clock, with no debounce.
- R8: `blank_o` is high, one clock later, whenever the state is not Normal.
- R9: A one-clock pulse on `mode_chg_i` raises `blank_o` on the next clock. `blank_o` then stays high for at least MODE_BLANK_US microsecond ticks.
- R10: `vblank_i` is ORed into `blank_o` with one clock of latency.
- R11: After reset the state is Off, amber is lit, the rail is disabled, blank is requested and both presence flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| vblank_i | input | 1 | Vertical retrace strobe, synchronous |
| mode_chg_i | input | 1 | One-clock flag that the measured display mode changed |
| pm_state_o | output | 2 | Adopted power state (R1 encoding) |
| hsync_ok_o | output | 1 | Hsync activity flag |
| vsync_ok_o | output | 1 | Vsync activity flag |
| led_green_o | output | 1 | Indicator green |
| led_amber_o | output | 1 | Indicator amber |
| rail_en_o | output | 1 | Deflection supply rail enable |
| blank_o | output | 1 | Combined blank request |

## Verification
The bench stops the syncs in every combination, including moving on from Standby to Off. It checks that the state has not moved while fewer interval pulses have elapsed than the debounce needs, and that it has moved once enough have. A design with a missing or short debounce would flip the state early. A design that also debounced the way back would leave the rail off for many intervals after both syncs return. The bench brackets the edges of each timeout and the mode-change hold from both sides, so an off-by-one in any tick count shows up as a flag or a blank level that is wrong at one of the sample points. Retrace blanking and reset values are checked as well.

// File: rtl/sync_pm_pkg.sv
package sync_pm_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'b00,
    PM_STANDBY = 2'b01,
    PM_SUSPEND = 2'b10,
    PM_OFF     = 2'b11
  } pm_state_t;

  // Map the two presence flags to the state they call for.
  function automatic pm_state_t pm_decode(input logic h_ok, input logic v_ok);
    pm_state_t s;
    case ({h_ok, v_ok})
      2'b11:   s = PM_NORMAL;
      2'b01:   s = PM_STANDBY;
      2'b10:   s = PM_SUSPEND;
      default: s = PM_OFF;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/spm_tick_gen.sv
module spm_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spm_activity.sv
module spm_activity #(
  parameter int TIMEOUT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic sync_i,
  output logic present_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic          s1_q, s2_q, s3_q;
  logic          edge_seen;
  logic [CW-1:0] age_q, age_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= sync_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    edge_seen = s2_q ^ s3_q;
    age_d     = age_q;
    if (edge_seen)                      age_d = '0;
    else if (tick_i && (age_q != LIMIT)) age_d = age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= LIMIT;
    else        age_q <= age_d;
  end

  assign present_o = (age_q != LIMIT);
endmodule

// File: rtl/spm_debounce.sv
module spm_debounce
  import sync_pm_pkg::*;
#(
  parameter int INTERVAL_TICKS = 100000,
  parameter int PERSIST        = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      h_ok_i,
  input  logic      v_ok_i,
  output pm_state_t state_o,
  output logic      ivl_pulse_o
);
  localparam int IW = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;
  localparam logic [IW-1:0] IVL_LAST = IW'(INTERVAL_TICKS - 1);
  localparam int PW = $clog2(PERSIST + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PERSIST - 1);

  logic [IW-1:0] ivl_q, ivl_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  pm_state_t     state_q, state_d, cand_q, cand_d, raw;

  always_comb begin
    ivl_pulse_o = tick_i && (ivl_q == IVL_LAST);
    ivl_d       = ivl_q;
    if (ivl_pulse_o) ivl_d = '0;
    else if (tick_i) ivl_d = ivl_q + 1'b1;
  end

  always_comb begin
    raw     = pm_decode(h_ok_i, v_ok_i);
    state_d = state_q;
    cand_d  = cand_q;
    pcnt_d  = pcnt_q;
    if (raw == PM_NORMAL) begin
      state_d = PM_NORMAL;
      cand_d  = PM_NORMAL;
      pcnt_d  = '0;
    end else if (raw == state_q) begin
      cand_d  = raw;
      pcnt_d  = '0;
    end else if (raw != cand_q) begin
      cand_d  = raw;
      pcnt_d  = '0;
    end else if (ivl_pulse_o) begin
      if (pcnt_q == P_LAST) begin
        state_d = cand_q;
        pcnt_d  = '0;
      end else begin
        pcnt_d  = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q   <= '0;
      pcnt_q  <= '0;
      state_q <= PM_OFF;
      cand_q  <= PM_OFF;
    end else begin
      ivl_q   <= ivl_d;
      pcnt_q  <= pcnt_d;
      state_q <= state_d;
      cand_q  <= cand_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/spm_out_stage.sv
module spm_out_stage
  import sync_pm_pkg::*;
#(
  parameter int HOLD_TICKS = 50000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  pm_state_t state_i,
  input  logic      mode_chg_i,
  input  logic      vblank_i,
  output logic      led_green_o,
  output logic      led_amber_o,
  output logic      rail_en_o,
  output logic      blank_o
);
  localparam int HW = $clog2(HOLD_TICKS + 2);
  localparam logic [HW-1:0] LOAD = HW'(HOLD_TICKS + 1);

  logic [HW-1:0] hold_q, hold_d;
  logic          normal;
  logic          green_d, amber_d, rail_d, blank_d;
  logic          green_q, amber_q, rail_q, blank_q;

  always_comb begin
    hold_d = hold_q;
    if (mode_chg_i)                     hold_d = LOAD;
    else if (tick_i && (hold_q != '0))  hold_d = hold_q - 1'b1;
  end

  always_comb begin
    normal  = (state_i == PM_NORMAL);
    green_d = normal;
    amber_d = !normal;
    rail_d  = normal;
    blank_d = !normal || (hold_q != '0) || mode_chg_i || vblank_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      green_q <= 1'b0;
      amber_q <= 1'b1;
      rail_q  <= 1'b0;
      blank_q <= 1'b1;
    end else begin
      hold_q  <= hold_d;
      green_q <= green_d;
      amber_q <= amber_d;
      rail_q  <= rail_d;
      blank_q <= blank_d;
    end
  end

  assign led_green_o = green_q;
  assign led_amber_o = amber_q;
  assign rail_en_o   = rail_q;
  assign blank_o     = blank_q;
endmodule

// File: rtl/sync_power_ctrl.sv
module sync_power_ctrl
  import sync_pm_pkg::*;
#(
  parameter int CLK_PER_US        = 50,
  parameter int HS_TIMEOUT_US     = 200,
  parameter int VS_TIMEOUT_US     = 100000,
  parameter int PERSIST_INTERVALS = 8,
  parameter int MODE_BLANK_US     = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_i,
  input  logic       vsync_i,
  input  logic       vblank_i,
  input  logic       mode_chg_i,
  output logic [1:0] pm_state_o,
  output logic       hsync_ok_o,
  output logic       vsync_ok_o,
  output logic       led_green_o,
  output logic       led_amber_o,
  output logic       rail_en_o,
  output logic       blank_o
);
  logic      rst_meta_q, rst_sync_q;
  logic      us_tick;
  logic      h_ok, v_ok;
  logic      ivl_pulse;
  pm_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  spm_tick_gen #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_sync_q), .tick_o(us_tick)
  );

  spm_activity #(.TIMEOUT(HS_TIMEOUT_US)) u_hs_act (
    .clk(clk), .rst_n(rst_sync_q), .tick_i(us_tick),
    .sync_i(hsync_i), .present_o(h_ok)
  );

  spm_activity #(.TIMEOUT(VS_TIMEOUT_US)) u_vs_act (
    .clk(clk), .rst_n(rst_sync_q), .tick_i(us_tick),
    .sync_i(vsync_i), .present_o(v_ok)
  );

  spm_debounce #(
    .INTERVAL_TICKS(VS_TIMEOUT_US), .PERSIST(PERSIST_INTERVALS)
  ) u_deb (
    .clk(clk), .rst_n(rst_sync_q), .tick_i(us_tick),
    .h_ok_i(h_ok), .v_ok_i(v_ok),
    .state_o(state), .ivl_pulse_o(ivl_pulse)
  );

  spm_out_stage #(.HOLD_TICKS(MODE_BLANK_US)) u_out (
    .clk(clk), .rst_n(rst_sync_q), .tick_i(us_tick),
    .state_i(state), .mode_chg_i(mode_chg_i), .vblank_i(vblank_i),
    .led_green_o(led_green_o), .led_amber_o(led_amber_o),
    .rail_en_o(rail_en_o), .blank_o(blank_o)
  );

  assign pm_state_o = state;
  assign hsync_ok_o = h_ok;
  assign vsync_ok_o = v_ok;
endmodule

// File: rtl/spm_checker.sv
module spm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       vblank_i,
  input logic       mode_chg_i,
  input logic [1:0] pm_state_o,
  input logic       hsync_ok_o,
  input logic       vsync_ok_o,
  input logic       led_green_o,
  input logic       led_amber_o,
  input logic       rail_en_o,
  input logic       blank_o,
  input logic       ivl_pulse
);
  p_led_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({led_green_o, led_amber_o}));

  p_rail_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state_o == 2'b00) |=> rail_en_o);

  p_rail_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state_o != 2'b00) |=> !rail_en_o);

  p_hold_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ivl_pulse && !(hsync_ok_o && vsync_ok_o)) |=> $stable(pm_state_o));

  p_fast_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_ok_o && vsync_ok_o) |=> (pm_state_o == 2'b00));

  p_saving_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state_o != 2'b00) |=> blank_o);

  p_mode_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_i |=> blank_o);

  p_retrace_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_i |=> blank_o);
endmodule

bind sync_power_ctrl spm_checker u_spm_checker (
  .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i), .mode_chg_i(mode_chg_i),
  .pm_state_o(pm_state_o), .hsync_ok_o(hsync_ok_o), .vsync_ok_o(vsync_ok_o),
  .led_green_o(led_green_o), .led_amber_o(led_amber_o),
  .rail_en_o(rail_en_o), .blank_o(blank_o), .ivl_pulse(ivl_pulse)
);

// File: tb/test_sync_power_ctrl.sv
`timescale 1ns/1ps
module test_sync_power_ctrl;
  localparam int CLK_PER_US = 2;
  localparam int HS_TO      = 5;
  localparam int VS_TO      = 20;
  localparam int PERSIST    = 3;
  localparam int HOLD       = 10;

  logic clk, rst_n, hsync, vsync, vblank, mode_chg;
  logic [1:0] pm_state;
  logic hs_ok, vs_ok, green, amber, rail, blank;

  int  cyc = 0;
  int  nchk = 0;
  int  nfail = 0;
  bit  hs_run = 0, vs_run = 0;
  int  hs_last = 0, vs_last = 0;
  bit  done = 0;

  sync_power_ctrl #(
    .CLK_PER_US(CLK_PER_US), .HS_TIMEOUT_US(HS_TO), .VS_TIMEOUT_US(VS_TO),
    .PERSIST_INTERVALS(PERSIST), .MODE_BLANK_US(HOLD)
  ) i_sync_power_ctrl (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .vblank_i(vblank), .mode_chg_i(mode_chg), .pm_state_o(pm_state),
    .hsync_ok_o(hs_ok), .vsync_ok_o(vs_ok), .led_green_o(green),
    .led_amber_o(amber), .rail_en_o(rail), .blank_o(blank)
  );

  initial begin
    clk = 0;
    forever #10 clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    hsync = 0;
    forever begin
      repeat (4) @(negedge clk);
      if (hs_run) begin hsync = ~hsync; hs_last = cyc; end
    end
  end

  initial begin
    vsync = 0;
    forever begin
      repeat (10) @(negedge clk);
      if (vs_run) begin vsync = ~vsync; vs_last = cyc; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int href, vref, ref_c, c0, exp_st;
    rst_n = 0; vblank = 0; mode_chg = 0;
    repeat (5) @(negedge clk);
    // R11: reset values
    chk("R11 state", pm_state, 3);
    chk("R11 amber", amber, 1);
    chk("R11 green", green, 0);
    chk("R11 rail", rail, 0);
    chk("R11 blank", blank, 1);
    chk("R11 hs_ok", hs_ok, 0);
    chk("R11 vs_ok", vs_ok, 0);
    rst_n = 1;
    hs_run = 1; vs_run = 1;
    c0 = cyc;
    wait_to(c0 + 24);
    // R7: Off to Normal without debounce; R4/R5 flags up
    chk("R7 state", pm_state, 0);
    chk("R4 hs_ok", hs_ok, 1);
    chk("R5 vs_ok", vs_ok, 1);
    chk("R2 green", green, 1);
    chk("R2 amber", amber, 0);
    chk("R3 rail", rail, 1);
    chk("R8 blank", blank, 0);

    // R10: retrace strobe
    @(negedge clk); vblank = 1;
    @(negedge clk); vblank = 0;
    chk("R10 blank on", blank, 1);
    @(negedge clk); @(negedge clk);
    chk("R10 blank off", blank, 0);

    // R9: mode-change hold
    @(negedge clk); mode_chg = 1; c0 = cyc;
    @(negedge clk); mode_chg = 0;
    chk("R9 blank start", blank, 1);
    wait_to(c0 + 20);
    chk("R9 blank held", blank, 1);
    wait_to(c0 + 28);
    chk("R9 blank released", blank, 0);

    // R1/R6 sweep: 0 stop hsync, 1 stop vsync, 2 stop both
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      hs_run = (k == 1);
      vs_run = (k == 0);
      href = hs_last; vref = vs_last;
      exp_st = (k == 0) ? 1 : (k == 1) ? 2 : 3;
      if (k != 1) begin
        wait_to(href + 8);  chk("R4 hs still ok", hs_ok, 1);
        wait_to(href + 16); chk("R4 hs timed out", hs_ok, 0);
      end
      if (k != 0) begin
        wait_to(vref + 30); chk("R5 vs still ok", vs_ok, 1);
        wait_to(vref + 50); chk("R5 vs timed out", vs_ok, 0);
      end
      ref_c = (k == 0) ? href + 14 : vref + 44;
      wait_to(ref_c + 48);
      chk("R6 not yet adopted", pm_state, 0);
      chk("R3 rail still on", rail, 1);
      wait_to(ref_c + 128);
      chk("R1 R6 adopted state", pm_state, exp_st);
      chk("R2 amber in saving", amber, 1);
      chk("R2 green in saving", green, 0);
      chk("R3 rail off", rail, 0);
      chk("R8 blank in saving", blank, 1);
      if (k == 0) begin
        // Standby to Off is debounced too
        @(negedge clk);
        vs_run = 0;
        vref = vs_last + 44;
        wait_to(vref + 48);
        chk("R6 standby kept", pm_state, 1);
        wait_to(vref + 128);
        chk("R6 off adopted", pm_state, 3);
      end
      @(negedge clk);
      hs_run = 1; vs_run = 1; c0 = cyc;
      wait_to(c0 + 20);
      chk("R7 fast return", pm_state, 0);
      @(negedge clk);
      chk("R3 rail restored", rail, 1);
      chk("R8 blank cleared", blank, 0);
    end

    finish_run();
  end
endmodule